// File: doc/BRIEF.md
# Shared-Bus Bank Selector with Byte/Word Width Adapter

This block connects one external memory bus to two internal memory ports, a flash port and an SRAM port. Three bank enables come from the bus: an active-low flash enable, an active-low SRAM enable and an active-high SRAM enable. They are sampled on every rising clock edge. The samples are decoded into one of four states. The state picks exactly one port, parks the block in standby, or flags a forbidden request in which both banks are selected at once. In the forbidden case neither port is enabled and nothing drives the bus.

A width-select input sets word mode (all data pins carry data) or byte mode. In byte mode only the lower byte of pins carries data. The middle pins float, and the top data pin is an input that acts as the byte address below the word address: 0 selects the low byte of the internal word and 1 selects the high byte, for both reads and writes. The block drives the per-pin output enables of the data bus. It also passes a word address, a write word and a two-bit byte-lane mask to the ports.

States (`bsel_state_e`): `ST_STANDBY`, `ST_FLASH`, `ST_SRAM`, `ST_CONFLICT`. Every rising edge loads the state that the sampled enables request, whatever the present state:
- flash request only goes to `ST_FLASH`;
- SRAM request only goes to `ST_SRAM`;
- both requests go to `ST_CONFLICT`;
- no request goes to `ST_STANDBY`.

Reset enters `ST_STANDBY`.

Top module: `bank_sel_adapter`

## Requirements
- R1: A low flash enable, with no SRAM request, makes `flash_sel` high and `sram_sel` low after the next rising edge.
- R2: An SRAM request exists only while the active-low SRAM enable is low and the active-high SRAM enable is high. If either condition is missing, `sram_sel` is low after the next edge.
- R3: With no request (flash enable high and the SRAM pair not both active), `standby` is high after the next edge and neither select is high. Reset also gives this state.
- R4: With both banks requested, `conflict_err` is high after the next edge. Neither select is high, `dq_oe` is all zero and both write strobes stay low, whatever `oe_n` and `we_n` are.
- R5: `dq_oe` is non-zero only while a port is selected and `oe_n` is low. Otherwise `dq_oe` is all zero and `dq_out` is zero.
- R6: In word mode (`wide_mode`=1) a read drives all 16 pins (`dq_oe`=16'hFFFF) with the selected port's read word (flash or SRAM).
- R7: In byte mode (`wide_mode`=0) a read gives `dq_oe`=16'h00FF. Pin 15 is never driven. `dq_out[7:0]` is the low byte of the read word when `dq_in[15]`=0 and the high byte when it is 1. `dq_out[15:8]` is zero.
- R8: A port's write strobe is high only while that port is selected, `we_n` is low and `oe_n` is high.
- R9: In word mode `wr_data`=`dq_in` and `lane_en`=2'b11. In byte mode `wr_data` is `dq_in[7:0]` copied into both bytes, and `lane_en` is 2'b01 when `dq_in[15]`=0 or 2'b10 when it is 1.
- R10: A change on the bank enables does not reach the selects before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_en_n | input | 1 | Flash bank enable, active low |
| sram_en_n | input | 1 | SRAM bank enable, active low |
| sram_en_hi | input | 1 | SRAM bank enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wide_mode | input | 1 | 1 = word mode, 0 = byte mode |
| addr_in | input | ADDR_W | Word address from the bus |
| dq_in | input | DQ_W | Data pins as seen from the bus |
| dq_out | output | DQ_W | Data to drive onto the pins |
| dq_oe | output | DQ_W | Per-pin output enable |
| flash_rdata | input | DQ_W | Read word from the flash port |
| sram_rdata | input | DQ_W | Read word from the SRAM port |
| mem_addr | output | ADDR_W | Word address to both ports |
| wr_data | output | DQ_W | Write word to both ports |
| lane_en | output | 2 | Byte lanes to write |
| flash_sel | output | 1 | Flash port selected |
| sram_sel | output | 1 | SRAM port selected |
| flash_wr | output | 1 | Flash write strobe |
| sram_wr | output | 1 | SRAM write strobe |
| standby | output | 1 | No port selected, no conflict |
| conflict_err | output | 1 | Both banks requested |

## Verification
The hardest case to reach from the ports is a forbidden request made while a read and a write are both being signalled. This is the only stimulus under which a wrong decode would drive the bus and strobe a port at the same moment. The bench first selects flash with `oe_n` and `we_n` both low. It then lowers the SRAM enable and raises the high-active SRAM enable in the same cycle, so the block goes straight from a driving state into the conflict state. Outputs are checked after that edge. A half-formed SRAM request, with only one of its two enables active, is also applied to show that it never selects the SRAM port.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY  = 2'd0,
        ST_FLASH    = 2'd1,
        ST_SRAM     = 2'd2,
        ST_CONFLICT = 2'd3
    } bsel_state_e;
endpackage

// File: rtl/bsel_decode.sv
module bsel_decode
    import bsel_pkg::*;
(
    input  logic        flash_en_n,
    input  logic        sram_en_n,
    input  logic        sram_en_hi,
    output bsel_state_e req_state
);
    logic flash_req;
    logic sram_req;

    always_comb begin
        flash_req = !flash_en_n;
        // the SRAM bank needs both of its enables active together
        sram_req  = !sram_en_n && sram_en_hi;
        unique case ({flash_req, sram_req})
            2'b10:   req_state = ST_FLASH;
            2'b01:   req_state = ST_SRAM;
            2'b11:   req_state = ST_CONFLICT;
            default: req_state = ST_STANDBY;
        endcase
    end
endmodule

// File: rtl/bsel_fsm.sv
module bsel_fsm
    import bsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bsel_state_e req_state,
    input  logic        oe_n,
    input  logic        we_n,
    output logic        flash_sel,
    output logic        sram_sel,
    output logic        standby,
    output logic        conflict_err,
    output logic        rd_active,
    output logic        flash_wr,
    output logic        sram_wr
);
    bsel_state_e state;
    logic        wr_ok;
    logic        rd_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STANDBY;
        else        state <= req_state;
    end

    always_comb begin
        wr_ok        = !we_n && oe_n;
        rd_ok        = !oe_n;
        flash_sel    = 1'b0;
        sram_sel     = 1'b0;
        standby      = 1'b0;
        conflict_err = 1'b0;
        rd_active    = 1'b0;
        flash_wr     = 1'b0;
        sram_wr      = 1'b0;
        unique case (state)
            ST_STANDBY: standby = 1'b1;
            ST_FLASH: begin
                flash_sel = 1'b1;
                rd_active = rd_ok;
                flash_wr  = wr_ok;
            end
            ST_SRAM: begin
                sram_sel  = 1'b1;
                rd_active = rd_ok;
                sram_wr   = wr_ok;
            end
            ST_CONFLICT: conflict_err = 1'b1;
            default: standby = 1'b1;
        endcase
    end

    assert_conflict_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_err |-> (!rd_active && !flash_wr && !sram_wr));
endmodule

// File: rtl/bsel_width.sv
module bsel_width #(
    parameter int DQ_W = 16
) (
    input  logic            wide_mode,
    input  logic            rd_active,
    input  logic [DQ_W-1:0] rd_word,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe,
    output logic [DQ_W-1:0] wr_data,
    output logic [1:0]      lane_en
);
    localparam int BYTE_W = DQ_W / 2;

    logic              hi_byte;
    logic [BYTE_W-1:0] rd_byte;

    // top pin doubles as the byte address in byte mode
    assign hi_byte = dq_in[DQ_W-1];
    assign rd_byte = hi_byte ? rd_word[DQ_W-1:BYTE_W] : rd_word[BYTE_W-1:0];

    genvar i;
    generate
        for (i = 0; i < DQ_W; i++) begin : g_pin
            if (i < BYTE_W) begin : g_lo
                assign dq_oe[i]  = rd_active;
                assign dq_out[i] = rd_active && (wide_mode ? rd_word[i] : rd_byte[i]);
            end else begin : g_hi
                assign dq_oe[i]  = rd_active && wide_mode;
                assign dq_out[i] = rd_active && wide_mode && rd_word[i];
            end
        end
    endgenerate

    always_comb begin
        if (wide_mode) begin
            wr_data = dq_in;
            lane_en = 2'b11;
        end else begin
            wr_data = {2{dq_in[BYTE_W-1:0]}};
            lane_en = hi_byte ? 2'b10 : 2'b01;
        end
    end
endmodule

// File: rtl/bank_sel_adapter.sv
module bank_sel_adapter
    import bsel_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_en_n,
    input  logic              sram_en_n,
    input  logic              sram_en_hi,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic [DQ_W-1:0]   dq_oe,
    input  logic [DQ_W-1:0]   flash_rdata,
    input  logic [DQ_W-1:0]   sram_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic [1:0]        lane_en,
    output logic              flash_sel,
    output logic              sram_sel,
    output logic              flash_wr,
    output logic              sram_wr,
    output logic              standby,
    output logic              conflict_err
);
    bsel_state_e     req_state;
    logic            rd_active;
    logic [DQ_W-1:0] rd_word;

    bsel_decode i_decode (
        .flash_en_n (flash_en_n),
        .sram_en_n  (sram_en_n),
        .sram_en_hi (sram_en_hi),
        .req_state  (req_state)
    );

    bsel_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_state    (req_state),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .flash_sel    (flash_sel),
        .sram_sel     (sram_sel),
        .standby      (standby),
        .conflict_err (conflict_err),
        .rd_active    (rd_active),
        .flash_wr     (flash_wr),
        .sram_wr      (sram_wr)
    );

    assign rd_word  = sram_sel ? sram_rdata : flash_rdata;
    assign mem_addr = addr_in;

    bsel_width #(.DQ_W(DQ_W)) i_width (
        .wide_mode (wide_mode),
        .rd_active (rd_active),
        .rd_word   (rd_word),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .wr_data   (wr_data),
        .lane_en   (lane_en)
    );

    assert_flash_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_en_n && (sram_en_n || !sram_en_hi)) |=> (flash_sel && !sram_sel));
    assert_sram_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_en_n || !sram_en_hi) |=> !sram_sel);
    assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_en_n && (sram_en_n || !sram_en_hi)) |=> (standby && !flash_sel && !sram_sel));
    assert_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_en_n && !sram_en_n && sram_en_hi) |=> (conflict_err && !flash_sel && !sram_sel));
    assert_bus_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || !(flash_sel || sram_sel)) |-> (dq_oe == '0));
    assert_pin_top_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> !dq_oe[DQ_W-1]);
    assert_wr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_wr || sram_wr) |-> (oe_n && !we_n));
endmodule

// File: tb/test_bank_sel_adapter.sv
module test_bank_sel_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_en_n = 1'b1, sram_en_n = 1'b1, sram_en_hi = 1'b0;
    logic        oe_n = 1'b1, we_n = 1'b1, wide_mode = 1'b1;
    logic [19:0] addr_in = '0;
    logic [15:0] dq_in = '0, flash_rdata = 16'hA5C3, sram_rdata = 16'h3C7E;
    logic [15:0] dq_out, dq_oe, wr_data;
    logic [19:0] mem_addr;
    logic [1:0]  lane_en;
    logic        flash_sel, sram_sel, flash_wr, sram_wr, standby, conflict_err;
    int          n_vec = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    bank_sel_adapter i_bank_sel_adapter (
        .clk(clk), .rst_n(rst_n), .flash_en_n(flash_en_n), .sram_en_n(sram_en_n),
        .sram_en_hi(sram_en_hi), .oe_n(oe_n), .we_n(we_n), .wide_mode(wide_mode),
        .addr_in(addr_in), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .flash_rdata(flash_rdata), .sram_rdata(sram_rdata), .mem_addr(mem_addr),
        .wr_data(wr_data), .lane_en(lane_en), .flash_sel(flash_sel), .sram_sel(sram_sel),
        .flash_wr(flash_wr), .sram_wr(sram_wr), .standby(standby), .conflict_err(conflict_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic f, input logic s, input logic sh, input logic o, input logic w);
        @(negedge clk);
        flash_en_n = f; sram_en_n = s; sram_en_hi = sh; oe_n = o; we_n = w;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        chk("R3 reset standby", {28'd0, standby, flash_sel, sram_sel, conflict_err}, 32'h8);
        chk("R5 reset dq_oe", dq_oe, 0);
    endtask

    task automatic t_flash_read;
        wide_mode = 1'b1;
        drive(0, 1, 0, 0, 1);
        chk("R1 flash_sel", {30'd0, flash_sel, sram_sel}, 32'h2);
        chk("R6 word dq_out", dq_out, 32'hA5C3);
        chk("R6 word dq_oe", dq_oe, 32'hFFFF);
        drive(0, 1, 0, 1, 1);
        chk("R5 oe_n high floats", dq_oe, 0);
        chk("R5 oe_n high dq_out", dq_out, 0);
    endtask

    task automatic t_sram_narrow;
        wide_mode = 1'b0;
        dq_in = 16'h8000;
        drive(1, 0, 1, 0, 1);
        chk("R2 sram_sel", {30'd0, flash_sel, sram_sel}, 32'h1);
        chk("R7 high byte", dq_out, 32'h003C);
        chk("R7 byte dq_oe", dq_oe, 32'h00FF);
        dq_in = 16'h0000;
        #2;
        chk("R7 low byte", dq_out, 32'h007E);
        wide_mode = 1'b1;
    endtask

    task automatic t_half_sram;
        drive(1, 0, 0, 0, 1);
        chk("R2 half request low-en only", {31'd0, sram_sel}, 0);
        chk("R3 standby half request", {31'd0, standby}, 1);
        drive(1, 1, 1, 0, 1);
        chk("R2 half request hi-en only", {31'd0, sram_sel}, 0);
        chk("R5 standby floats", dq_oe, 0);
    endtask

    task automatic t_conflict;
        drive(0, 1, 0, 0, 0);
        drive(0, 0, 1, 0, 0);
        chk("R4 conflict flags", {28'd0, standby, flash_sel, sram_sel, conflict_err}, 32'h1);
        chk("R4 conflict floats", dq_oe, 0);
        drive(0, 0, 1, 1, 0);
        chk("R4 conflict no strobes", {30'd0, flash_wr, sram_wr}, 0);
    endtask

    task automatic t_write;
        wide_mode = 1'b1;
        dq_in = 16'h1234;
        addr_in = 20'h5A5A5;
        drive(0, 1, 0, 1, 0);
        chk("R8 flash strobe", {30'd0, flash_wr, sram_wr}, 32'h2);
        chk("R9 word data", wr_data, 32'h1234);
        chk("R9 word lanes", lane_en, 32'h3);
        chk("R9 address", mem_addr, 32'h5A5A5);
        drive(0, 1, 0, 0, 0);
        chk("R8 oe_n low blocks write", {30'd0, flash_wr, sram_wr}, 0);
        wide_mode = 1'b0;
        dq_in = 16'h8055;
        drive(1, 0, 1, 1, 0);
        chk("R8 sram strobe", {30'd0, flash_wr, sram_wr}, 32'h1);
        chk("R9 byte data hi", wr_data, 32'h5555);
        chk("R9 byte lanes hi", lane_en, 32'h2);
        dq_in = 16'h0042;
        #2;
        chk("R9 byte data lo", wr_data, 32'h4242);
        chk("R9 byte lanes lo", lane_en, 32'h1);
        wide_mode = 1'b1;
    endtask

    task automatic t_latency;
        drive(1, 1, 0, 1, 1);
        @(negedge clk);
        flash_en_n = 1'b0;
        #2;
        chk("R10 no change before edge", {31'd0, flash_sel}, 0);
        @(posedge clk);
        #2;
        chk("R10 change after edge", {31'd0, flash_sel}, 1);
    endtask

    initial begin
        #1;
        chk("R3 standby in reset", {31'd0, standby}, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        t_reset();
        t_flash_read();
        t_sram_narrow();
        t_half_sram();
        t_conflict();
        t_write();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule